// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block sequences a small multicycle load/store processor whose datapath shares one ALU and one memory port across all phases. A phase counter walks a fixed loop of five phases: instruction fetch, register decode, execute, memory and write back. It moves one phase per clock. From the current phase and from the opcode and function fields of the held instruction, the block drives every datapath strobe. These cover the memory read and write strobes, the instruction and program-counter enables, the operand-register and ALU-result enables, the register-file write together with its destination and data selects, the two ALU operand selects and a 2-bit ALU operation code.

Four register-to-register operations are supported (add, subtract, and, or), along with a word load and a word store. Every instruction takes the full five phases. Any phase that a given instruction does not need leaves all strobes low. All outputs are combinational in the phase register and the instruction fields, so each strobe is valid within the cycle of its phase.

Top module: `mc_ctrl_seq`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the phase returns to fetch. The cycle after that edge shows the fetch strobes of R3, even when the reset arrives partway through an instruction.
- R2: Phases advance one per clock in a fixed order: fetch, decode, execute, memory, write back, then fetch again. Every instruction takes exactly five cycles, whatever its opcode.
- R3: In fetch, `mem_rd`, `ir_en` and `pc_en` are 1. `srca_sel_a`=0 (PC), `srcb_sel`=00 (constant 4) and `alu_op`=00 (add). Every other strobe is 0.
- R4: In decode, only `ab_load` is 1. All other outputs are 0.
- R5: In execute, a register-type instruction (opcode 000000) with a recognised function code drives `srca_sel_a`=1, `srcb_sel`=01 (B) and `out_load`=1. Its `alu_op` is 00 for function 100000 (add), 01 for 100010 (sub), 10 for 100100 (and) and 11 for 100101 (or).
- R6: In execute, a load (opcode 100011) or a store (opcode 101011) drives `srca_sel_a`=1, `srcb_sel`=10 (sign-extended immediate), `alu_op`=00 and `out_load`=1.
- R7: In the memory phase, a recognised register-type instruction drives `rf_we`=1, `dst_sel_rd`=1 (rd field) and `wb_sel_mdr`=0 (ALU result). All else is 0.
- R8: In the memory phase, a load drives only `mem_rd`=1 and a store drives only `mem_wr`=1.
- R9: In write back, a load drives `rf_we`=1, `dst_sel_rd`=0 (rt field) and `wb_sel_mdr`=1 (memory data). All else is 0.
- R10: In write back, a register-type instruction or a store drives every output to 0.
- R11: An unrecognised opcode, or opcode 000000 with an unrecognised function code, drives every output to 0 in execute, memory and write back.
- R12: `mem_rd` and `mem_wr` are never 1 together, and `rf_we` is never 1 together with `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 6 | Opcode field of the held instruction |
| fn_code | input | 6 | Function field of the held instruction |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_en | output | 1 | Instruction register load enable |
| pc_en | output | 1 | Program counter load enable |
| ab_load | output | 1 | Operand registers A and B load enable |
| out_load | output | 1 | ALU result register load enable |
| rf_we | output | 1 | Register file write enable |
| dst_sel_rd | output | 1 | Write register select: 0 rt field, 1 rd field |
| wb_sel_mdr | output | 1 | Write data select: 0 ALU result, 1 memory data |
| srca_sel_a | output | 1 | ALU operand A select: 0 PC, 1 register A |
| srcb_sel | output | 2 | ALU operand B select: 00 constant 4, 01 register B, 10 immediate |
| alu_op | output | 2 | ALU operation: 00 add, 01 sub, 10 and, 11 or |

## Verification
The bench builds the block with its default parameters: 6-bit opcode and function fields and the standard encodings. At that size, all 4096 opcode and function combinations can each be run through a complete five-phase instruction. Every output is compared in every phase, so the unrecognised codes and the near-miss function codes are covered in full and not just sampled. A reset applied in the middle of a load checks the return to fetch from a phase other than write back.

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq #(
  parameter int OPW = 6,
  parameter int FNW = 6,
  parameter logic [OPW-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OPW-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OPW-1:0] OP_STORE = 6'b101011,
  parameter logic [FNW-1:0] FN_ADD   = 6'b100000,
  parameter logic [FNW-1:0] FN_SUB   = 6'b100010,
  parameter logic [FNW-1:0] FN_AND   = 6'b100100,
  parameter logic [FNW-1:0] FN_OR    = 6'b100101
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_code,
  input  logic [FNW-1:0] fn_code,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           ir_en,
  output logic           pc_en,
  output logic           ab_load,
  output logic           out_load,
  output logic           rf_we,
  output logic           dst_sel_rd,
  output logic           wb_sel_mdr,
  output logic           srca_sel_a,
  output logic [1:0]     srcb_sel,
  output logic [1:0]     alu_op
);

  typedef enum logic [2:0] {PH_IF, PH_ID, PH_EX, PH_MEM, PH_WB} phase_t;

  phase_t     ph, ph_nxt;
  logic       is_r, is_ld, is_st, fn_ok, r_ok, mref;
  logic [1:0] r_alu;

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_IF;
    else     ph <= ph_nxt;
  end

  always_comb begin
    case (ph)
      PH_IF:   ph_nxt = PH_ID;
      PH_ID:   ph_nxt = PH_EX;
      PH_EX:   ph_nxt = PH_MEM;
      PH_MEM:  ph_nxt = PH_WB;
      default: ph_nxt = PH_IF;
    endcase
  end

  assign is_r  = (op_code == OP_RTYPE);
  assign is_ld = (op_code == OP_LOAD);
  assign is_st = (op_code == OP_STORE);
  assign mref  = is_ld | is_st;

  always_comb begin
    fn_ok = 1'b1;
    case (fn_code)
      FN_ADD:  r_alu = 2'b00;
      FN_SUB:  r_alu = 2'b01;
      FN_AND:  r_alu = 2'b10;
      FN_OR:   r_alu = 2'b11;
      default: begin r_alu = 2'b00; fn_ok = 1'b0; end
    endcase
  end

  assign r_ok = is_r & fn_ok;

  wire in_if  = (ph == PH_IF);
  wire in_ex  = (ph == PH_EX);
  wire in_mem = (ph == PH_MEM);
  wire in_wb  = (ph == PH_WB);

  assign mem_rd     = in_if | (in_mem & is_ld);
  assign mem_wr     = in_mem & is_st;
  assign ir_en      = in_if;
  assign pc_en      = in_if;
  assign ab_load    = (ph == PH_ID);
  assign out_load   = in_ex & (r_ok | mref);
  assign rf_we      = (in_mem & r_ok) | (in_wb & is_ld);
  assign dst_sel_rd = in_mem & r_ok;
  assign wb_sel_mdr = in_wb & is_ld;
  assign srca_sel_a = in_ex & (r_ok | mref);
  assign srcb_sel   = !in_ex ? 2'b00 : r_ok ? 2'b01 : mref ? 2'b10 : 2'b00;
  assign alu_op     = (in_ex & r_ok) ? r_alu : 2'b00;

  assert_mem_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr) && !(rf_we && mem_wr));

  assert_decode_after_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    ir_en |=> (ab_load && !ir_en && !mem_rd));

  assert_fetch_operands_R3: assert property (@(posedge clk) disable iff (rst)
    ir_en |-> (pc_en && mem_rd && !srca_sel_a && srcb_sel == 2'b00 && alu_op == 2'b00));

  assert_exec_then_quiet_alu_R6: assert property (@(posedge clk) disable iff (rst)
    out_load |=> (!out_load && !ab_load && !ir_en && !srca_sel_a));

  assert_store_idle_wb_R10: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (!rf_we && !mem_rd && !mem_wr && !ir_en));

  assert_load_wb_follows_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rf_we && wb_sel_mdr) |-> ($past(mem_rd) && !$past(ir_en) && !dst_sel_rd));

endmodule

// File: tb/tb_mc_ctrl_seq.sv
module tb_mc_ctrl_seq;
  localparam time TCK = 20ns;

  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] op_code = '0, fn_code = '0;
  logic mem_rd, mem_wr, ir_en, pc_en, ab_load, out_load, rf_we;
  logic dst_sel_rd, wb_sel_mdr, srca_sel_a;
  logic [1:0] srcb_sel, alu_op;
  int n_chk = 0, n_bad = 0;

  always #(TCK/2) clk = ~clk;

  mc_ctrl_seq dut (
    .clk(clk), .rst(rst), .op_code(op_code), .fn_code(fn_code),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_en(ir_en), .pc_en(pc_en),
    .ab_load(ab_load), .out_load(out_load), .rf_we(rf_we),
    .dst_sel_rd(dst_sel_rd), .wb_sel_mdr(wb_sel_mdr), .srca_sel_a(srca_sel_a),
    .srcb_sel(srcb_sel), .alu_op(alu_op)
  );

  wire [13:0] got = {mem_rd, mem_wr, ir_en, pc_en, ab_load, out_load, rf_we,
                     dst_sel_rd, wb_sel_mdr, srca_sel_a, srcb_sel, alu_op};

  // Expected outputs built from the requirement text, same packing as got.
  function automatic logic [13:0] want(int ph, logic [5:0] op, logic [5:0] fn);
    logic rd = 0, wr = 0, ir = 0, pc = 0, ab = 0, ol = 0, we = 0, dst = 0, wb = 0, sa = 0;
    logic [1:0] sb = 2'b00, ao = 2'b00, fa = 2'b00;
    bit ld = (op == 6'b100011), st = (op == 6'b101011), fok = 1;
    case (fn)
      6'b100000: fa = 2'b00;
      6'b100010: fa = 2'b01;
      6'b100100: fa = 2'b10;
      6'b100101: fa = 2'b11;
      default:   fok = 0;
    endcase
    fok = fok && (op == 6'b000000);
    case (ph)
      0: begin rd = 1; ir = 1; pc = 1; end
      1: ab = 1;
      2: if (fok) begin sa = 1; sb = 2'b01; ol = 1; ao = fa; end
         else if (ld || st) begin sa = 1; sb = 2'b10; ol = 1; end
      3: if (fok) begin we = 1; dst = 1; end
         else if (ld) rd = 1;
         else if (st) wr = 1;
      default: if (ld) begin we = 1; wb = 1; end
    endcase
    return {rd, wr, ir, pc, ab, ol, we, dst, wb, sa, sb, ao};
  endfunction

  function automatic string tag(int ph, logic [5:0] op, logic [5:0] fn);
    bit mr = (op == 6'b100011) || (op == 6'b101011);
    bit rk = (op == 6'b000000) && (fn inside {6'b100000, 6'b100010, 6'b100100, 6'b100101});
    if (ph == 0) return "R2,R3";
    if (ph == 1) return "R2,R4";
    if (!mr && !rk) return "R11";
    if (ph == 2) return rk ? "R5" : "R6";
    if (ph == 3) return rk ? "R7" : "R8";
    return (op == 6'b100011) ? "R9" : "R10";
  endfunction

  task automatic check(string req, logic [13:0] exp_v);
    n_chk++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%b fn=%b got=%b exp=%b", req, op_code, fn_code, got, exp_v);
    end
    n_chk++;
    if ((mem_rd && mem_wr) || (rf_we && mem_wr)) begin
      n_bad++;
      $display("FAIL R12 got rd/wr/we=%b%b%b exp no overlap", mem_rd, mem_wr, rf_we);
    end
  endtask

  // Entered just after a negedge with the phase at fetch; leaves at the next fetch.
  task automatic run_instr(logic [5:0] op, logic [5:0] fn);
    op_code = op; fn_code = fn;
    #1 check(tag(0, op, fn), want(0, op, fn));
    for (int p = 1; p < 5; p++) begin
      @(negedge clk);
      #1 check(tag(p, op, fn), want(p, op, fn));
    end
    @(negedge clk);
  endtask

  initial begin
    #(TCK * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 check("R1", want(0, 6'b0, 6'b0));
    rst = 1'b0;
    for (int o = 0; o < 64; o++)
      for (int f = 0; f < 64; f++)
        run_instr(6'(o), 6'(f));
    // R1: reset in the execute phase of a load
    op_code = 6'b100011;
    @(negedge clk); @(negedge clk);
    #1 check("R6", want(2, 6'b100011, 6'b0));
    rst = 1'b1;
    @(negedge clk);
    #1 check("R1", want(0, 6'b100011, 6'b0));
    rst = 1'b0;
    run_instr(6'b100011, 6'b0);
    run_instr(6'b000000, 6'b100101);
    run_instr(6'b101011, 6'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule